// File: doc/BRIEF.md
# Parallel Mask-Based Cluster Reducer

The block holds a binary hit matrix and reduces every cluster of neighbouring hits to a single surviving pixel. Software first loads a list of thinning rules. Each rule is a pair of 8-bit masks over the eight neighbours of a pixel. Hits are then written one pixel at a time and a start pulse begins the reduction. On each cycle one rule is evaluated for every pixel at once, and every hit that matches the rule is removed.

The rules are applied in list order, one per cycle. The list is repeated until a whole pass through it removes nothing. The block then raises its done flag and streams the surviving pixel addresses out over a valid/ready handshake. These addresses are approximate cluster centres. A large cluster may leave more than one survivor. Two hits that remove each other in the same step may leave none.

Each accepted address clears its pixel. When the matrix is empty the block returns to idle, ready for the next frame.

Top module: `cluster_reducer`

## Requirements
- R1: After reset, done and out_valid are 0, the matrix is empty and every rule holds zero masks.
- R2: A hit write (hit_we) in the idle state sets the pixel at (hit_row, hit_col). A hit write issued while reducing or streaming is ignored and never appears in the output.
- R3: A rule clears a hit pixel when the neighbour bits selected by its need mask contain at least one hit and the neighbour bits selected by its vacant mask are all clear. The neighbour bit order is 0=NW, 1=N, 2=NE, 3=W, 4=E, 5=SW, 6=S, 7=SE, with row numbers growing downward and column numbers growing rightward. Positions outside the matrix count as empty.
- R4: A rule step evaluates every pixel against the matrix as it stood before that step. Two adjacent hits that each satisfy the rule are both removed in the same step.
- R5: A start pulse applies rules 0 to rule_cnt-1, in that order, one per cycle. A rule_cnt larger than the rule file size uses every rule. A rule_cnt of 0 skips reduction, so every loaded hit survives.
- R6: Reduction ends after a complete pass through the rules in which no pixel changed. done is then 1 until every survivor has been accepted, after which the block returns to idle with done at 0.
- R7: Survivors are presented in ascending row-major order (lower row first, then lower column). There is one address per accepted transfer (out_valid and out_ready both 1), and no address repeats.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_row and out_col hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_we | input | 1 | Set one pixel of the matrix (idle only) |
| hit_row | input | $clog2(ROWS) | Row of the pixel to set |
| hit_col | input | $clog2(COLS) | Column of the pixel to set |
| rule_we | input | 1 | Write one rule (idle only) |
| rule_sel | input | RULE_AW | Rule slot to write |
| rule_need | input | 8 | Neighbours of which at least one must be hit |
| rule_vacant | input | 8 | Neighbours that must all be empty |
| rule_cnt | input | RULE_AW+1 | Number of rules to apply, sampled at start |
| start | input | 1 | Begin reduction (idle only) |
| done | output | 1 | Reduction finished; survivors are being streamed |
| out_valid | output | 1 | A survivor address is presented |
| out_ready | input | 1 | Consumer accepts the presented address |
| out_row | output | $clog2(ROWS) | Row of the presented survivor |
| out_col | output | $clog2(COLS) | Column of the presented survivor |

## Verification
The assertions check four things on every cycle. The matrix never gains a hit while reducing. No pixel is cleared unless it holds a hit. The presented survivor is the lowest-numbered set pixel. A stalled output stays steady. Only the bench scenarios can show the rest, because it depends on the rule contents and the loaded pattern. That covers which pixels survive under a given rule set, how the edges are treated, that adjacent hits are removed at the same moment, how rule_cnt is handled, and that writes issued outside idle are dropped.

// File: rtl/cr_pkg.sv
package cr_pkg;
   // neighbour bit order inside a rule mask
   localparam int NB_NW = 0;
   localparam int NB_N  = 1;
   localparam int NB_NE = 2;
   localparam int NB_W  = 3;
   localparam int NB_E  = 4;
   localparam int NB_SW = 5;
   localparam int NB_S  = 6;
   localparam int NB_SE = 7;
   localparam int NB_COUNT = 8;

   typedef struct packed {
      logic [NB_COUNT-1:0] need;
      logic [NB_COUNT-1:0] vacant;
   } cr_rule_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_READ
   } cr_state_e;
endpackage

// File: rtl/cr_rule_file.sv
module cr_rule_file
   import cr_pkg::*;
#(
   parameter int RULE_AW = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [RULE_AW-1:0] wr_sel,
   input  cr_rule_t           wr_rule,
   input  logic [RULE_AW-1:0] rd_sel,
   output cr_rule_t           rd_rule
);
   localparam int NRULES = 2 ** RULE_AW;

   cr_rule_t slots [NRULES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NRULES; i++) slots[i] <= '0;
      end else if (wr_en) begin
         slots[wr_sel] <= wr_rule;
      end
   end

   assign rd_rule = slots[rd_sel];
endmodule

// File: rtl/cr_thin_array.sv
module cr_thin_array
   import cr_pkg::*;
#(
   parameter int ROWS = 8,
   parameter int COLS = 8
) (
   input  logic [ROWS*COLS-1:0] hits,
   input  cr_rule_t             rule,
   output logic [ROWS*COLS-1:0] clr
);
   // matrix surrounded by a ring of permanently empty cells
   logic [ROWS+1:0][COLS+1:0] pad;

   always_comb begin
      pad = '0;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            pad[r+1][c+1] = hits[r*COLS+c];
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         logic [NB_COUNT-1:0] nb;
         logic                any_need, any_block;
         assign nb = {pad[r+2][c+2], pad[r+2][c+1], pad[r+2][c],
                      pad[r+1][c+2], pad[r+1][c],
                      pad[r][c+2],   pad[r][c+1],   pad[r][c]};
         assign any_need  = |(nb & rule.need);
         assign any_block = |(nb & rule.vacant);
         assign clr[r*COLS+c] = hits[r*COLS+c] & any_need & ~any_block;
      end
   end
endmodule

// File: rtl/cr_pick.sv
module cr_pick #(
   parameter int N  = 64,
   parameter int AW = 6
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [AW-1:0] idx
);
   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--)
         if (vec[i]) idx = AW'(i);
   end
endmodule

// File: rtl/cluster_reducer.sv
module cluster_reducer
   import cr_pkg::*;
#(
   parameter int ROWS    = 8,
   parameter int COLS    = 8,
   parameter int RULE_AW = 3,
   localparam int RW     = $clog2(ROWS),
   localparam int CW     = $clog2(COLS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit_we,
   input  logic [RW-1:0]      hit_row,
   input  logic [CW-1:0]      hit_col,
   input  logic               rule_we,
   input  logic [RULE_AW-1:0] rule_sel,
   input  logic [7:0]         rule_need,
   input  logic [7:0]         rule_vacant,
   input  logic [RULE_AW:0]   rule_cnt,
   input  logic               start,
   output logic               done,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [RW-1:0]      out_row,
   output logic [CW-1:0]      out_col
);
   localparam int N      = ROWS * COLS;
   localparam int AW     = $clog2(N);
   localparam int NRULES = 2 ** RULE_AW;

   if (ROWS < 2) begin : g_bad_rows
      $error("cluster_reducer: ROWS must be at least 2");
   end
   if (COLS < 2) begin : g_bad_cols
      $error("cluster_reducer: COLS must be at least 2");
   end
   if (RULE_AW < 1) begin : g_bad_rules
      $error("cluster_reducer: RULE_AW must be at least 1");
   end

   cr_state_e          state;
   logic [N-1:0]       matrix;
   logic [N-1:0]       wmask;
   logic [N-1:0]       clr;
   logic [RULE_AW-1:0] rule_idx, last_rule;
   logic               pass_chg;
   logic               any_clr;
   cr_rule_t           cur_rule, new_rule;
   logic               pick_found;
   logic [AW-1:0]      pick_idx;

   assign new_rule = '{need: rule_need, vacant: rule_vacant};

   cr_rule_file #(.RULE_AW(RULE_AW)) u_rules (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rule_we && state == ST_IDLE),
      .wr_sel  (rule_sel),
      .wr_rule (new_rule),
      .rd_sel  (rule_idx),
      .rd_rule (cur_rule)
   );

   cr_thin_array #(.ROWS(ROWS), .COLS(COLS)) u_thin (
      .hits (matrix),
      .rule (cur_rule),
      .clr  (clr)
   );

   cr_pick #(.N(N), .AW(AW)) u_pick (
      .vec   (matrix),
      .found (pick_found),
      .idx   (pick_idx)
   );

   // one-hot decode of the write address; out-of-range hits nothing
   always_comb begin
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            wmask[r*COLS+c] = hit_we && (hit_row == RW'(r)) && (hit_col == CW'(c));
   end

   assign any_clr = |clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         matrix    <= '0;
         rule_idx  <= '0;
         last_rule <= '0;
         pass_chg  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               matrix <= matrix | wmask;
               if (start) begin
                  rule_idx <= '0;
                  pass_chg <= 1'b0;
                  if (rule_cnt == '0) begin
                     state <= ST_READ;
                  end else begin
                     state <= ST_RUN;
                     if (rule_cnt > (RULE_AW+1)'(NRULES))
                        last_rule <= RULE_AW'(NRULES - 1);
                     else
                        last_rule <= RULE_AW'(rule_cnt - 1'b1);
                  end
               end
            end
            ST_RUN: begin
               matrix <= matrix & ~clr;
               if (rule_idx == last_rule) begin
                  rule_idx <= '0;
                  pass_chg <= 1'b0;
                  if (!pass_chg && !any_clr) state <= ST_READ;
               end else begin
                  rule_idx <= rule_idx + 1'b1;
                  pass_chg <= pass_chg | any_clr;
               end
            end
            ST_READ: begin
               if (pick_found && out_ready)
                  matrix <= matrix & ~(N'(1) << pick_idx);
               if (!pick_found) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done      = (state == ST_READ);
   assign out_valid = done && pick_found;
   assign out_row   = RW'(pick_idx / AW'(COLS));
   assign out_col   = CW'(pick_idx % AW'(COLS));

   // R3
   clear_only_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |-> ((clr & ~matrix) == '0));

   // R2
   no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |=> ((matrix & ~$past(matrix)) == '0));

   // R7
   lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_found |-> (matrix[pick_idx] && ((matrix & ((N'(1) << pick_idx) - 1'b1)) == '0)));

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_col)));
endmodule

// File: tb/tb_cluster_reducer.sv
`timescale 1ns/1ps
module tb_cluster_reducer;
   localparam int ROWS = 8, COLS = 8, RULE_AW = 3;
   localparam int RW = $clog2(ROWS), CW = $clog2(COLS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hit_we = 1'b0;
   logic [RW-1:0] hit_row = '0;
   logic [CW-1:0] hit_col = '0;
   logic rule_we = 1'b0;
   logic [RULE_AW-1:0] rule_sel = '0;
   logic [7:0] rule_need = '0, rule_vacant = '0;
   logic [RULE_AW:0] rule_cnt = '0;
   logic start = 1'b0;
   logic done, out_valid;
   logic out_ready = 1'b1;
   logic [RW-1:0] out_row;
   logic [CW-1:0] out_col;

   int errors = 0, checks = 0;
   int gr[32], gc[32], ng;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cluster_reducer #(.ROWS(ROWS), .COLS(COLS), .RULE_AW(RULE_AW)) dut (
      .clk(clk), .rst_n(rst_n), .hit_we(hit_we), .hit_row(hit_row), .hit_col(hit_col),
      .rule_we(rule_we), .rule_sel(rule_sel), .rule_need(rule_need),
      .rule_vacant(rule_vacant), .rule_cnt(rule_cnt), .start(start), .done(done),
      .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .out_col(out_col));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic put_hit(input int r, input int c);
      @(negedge clk);
      hit_we = 1'b1; hit_row = RW'(r); hit_col = CW'(c);
      @(negedge clk);
      hit_we = 1'b0;
   endtask

   task automatic put_rule(input int i, input logic [7:0] need, input logic [7:0] vac);
      @(negedge clk);
      rule_we = 1'b1; rule_sel = RULE_AW'(i); rule_need = need; rule_vacant = vac;
      @(negedge clk);
      rule_we = 1'b0;
   endtask

   // pulses start and returns at the negedge where done is first seen
   task automatic run(input int cnt, input bit rdy, output bit seen);
      @(negedge clk);
      out_ready = rdy;
      rule_cnt = (RULE_AW+1)'(cnt);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seen = 1'b0;
      for (int k = 0; k < 2000; k++) begin
         if (done) begin seen = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic collect();
      out_ready = 1'b1;
      ng = 0;
      for (int k = 0; k < 200; k++) begin
         if (!done) break;
         if (out_valid && ng < 32) begin
            gr[ng] = int'(out_row); gc[ng] = int'(out_col); ng++;
         end
         @(negedge clk);
      end
   endtask

   task automatic expect_list(input string tag, input int n, input int er[4], input int ec[4]);
      chk(ng == n, {tag, " survivor count"}, ng, n);
      for (int i = 0; i < n && i < ng; i++) begin
         chk(gr[i] == er[i], {tag, " row"}, gr[i], er[i]);
         chk(gc[i] == ec[i], {tag, " col"}, gc[i], ec[i]);
      end
      chk(done == 1'b0, {tag, " back to idle"}, int'(done), 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(done == 1'b0, "R1 done after reset", int'(done), 0);
      chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
   endtask

   // rules from reset have zero need masks and clear nothing; empty matrix yields nothing
   task automatic t_empty_frame();
      bit seen;
      run(8, 1'b1, seen);
      chk(seen, "R1 empty frame done", int'(seen), 1);
      chk(out_valid == 1'b0, "R1 empty frame no survivor", int'(out_valid), 0);
      collect();
      chk(ng == 0, "R1 empty frame count", ng, 0);
   endtask

   task automatic t_single();
      bit seen;
      put_rule(0, 8'h08, 8'h00);   // need W
      put_hit(3, 4);
      run(1, 1'b1, seen);
      chk(seen, "R6 single done", int'(seen), 1);
      collect();
      expect_list("R6 single", 1, '{3, 0, 0, 0}, '{4, 0, 0, 0});
   endtask

   task automatic t_parallel();
      bit seen;
      put_rule(0, 8'h18, 8'h00);   // need W or E
      put_hit(1, 1);
      put_hit(1, 2);
      run(1, 1'b1, seen);
      chk(seen, "R4 mutual removal done", int'(seen), 1);
      chk(out_valid == 1'b0, "R4 mutual removal valid", int'(out_valid), 0);
      collect();
      chk(ng == 0, "R4 both removed", ng, 0);
   endtask

   task automatic t_vacant();
      bit seen;
      put_rule(0, 8'h08, 8'h10);   // need W, E must be empty
      put_hit(5, 3);
      put_hit(5, 1);
      put_hit(5, 2);
      run(1, 1'b1, seen);
      collect();
      expect_list("R3 vacant mask", 1, '{5, 0, 0, 0}, '{1, 0, 0, 0});
   endtask

   task automatic t_edges();
      bit seen;
      put_rule(0, 8'h0B, 8'h00);   // NW|N|W
      put_rule(1, 8'hF0, 8'h00);   // E|SW|S|SE
      put_hit(7, 7);
      put_hit(0, 5);
      put_hit(0, 0);
      run(2, 1'b1, seen);
      collect();
      expect_list("R3 R7 edges and order", 3, '{0, 0, 7, 0}, '{0, 5, 7, 0});
   endtask

   task automatic t_count();
      bit seen;
      put_rule(0, 8'h08, 8'h00);   // need W
      put_rule(1, 8'h02, 8'h00);   // need N
      put_hit(3, 3); put_hit(4, 3);
      run(1, 1'b1, seen);
      collect();
      expect_list("R5 count one", 2, '{3, 4, 0, 0}, '{3, 3, 0, 0});
      put_hit(3, 3); put_hit(4, 3);
      run(2, 1'b1, seen);
      collect();
      expect_list("R5 count two", 1, '{3, 0, 0, 0}, '{3, 0, 0, 0});
      put_hit(4, 3); put_hit(3, 3);
      run(0, 1'b1, seen);
      chk(seen, "R5 count zero done", int'(seen), 1);
      collect();
      expect_list("R5 count zero", 2, '{3, 4, 0, 0}, '{3, 3, 0, 0});
      put_hit(3, 3); put_hit(4, 3);
      run(15, 1'b1, seen);
      collect();
      expect_list("R5 count clamped", 1, '{3, 0, 0, 0}, '{3, 0, 0, 0});
   endtask

   task automatic t_stall();
      bit seen;
      put_rule(0, 8'h08, 8'h00);
      put_hit(6, 1); put_hit(2, 6);
      run(1, 1'b0, seen);
      chk(out_valid == 1'b1, "R8 valid at done", int'(out_valid), 1);
      chk(out_row == 2 && out_col == 6, "R8 first address", int'(out_row)*8+int'(out_col), 22);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
         chk(out_row == 2 && out_col == 6, "R8 address held", int'(out_row)*8+int'(out_col), 22);
      end
      hit_we = 1'b1; hit_row = '0; hit_col = '0;   // write while streaming
      @(negedge clk);
      hit_we = 1'b0;
      collect();
      expect_list("R2 write while streaming ignored", 2, '{2, 6, 0, 0}, '{6, 1, 0, 0});
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_empty_frame();
      t_single();
      t_parallel();
      t_vacant();
      t_edges();
      t_count();
      t_stall();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         finished = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule